// File: doc/BRIEF.md
# DLL power-up sequencer

This block brings up the delay-locked loop of an SD/MMC host controller in hardware, so that software does not have to step through the bring-up by hand. A one-cycle start request launches a fixed programming run over a small internal bank of control registers: a clock-control word that holds the power-save bit, three DLL configuration words, a DDR configuration word, a user-control word, a test-control word, and a status word that captures the DLL lock indication. Each programming step appears on a write-observation port at the moment it is issued, and the DLL control bits (reset, power-down, clock-disable, clock-output enable) are brought out from the bank's registers.

The run turns power saving off and puts the DLL into reset and power-down with its clock gated. It then loads the configuration words, using per-board override values where a valid, non-zero value is supplied and power-on defaults otherwise. After a timed settle of about 52 µs it releases the DLL, pulses its reset, and ungates its clock. It then waits for a parameterised number of DLL input-clock ticks, enables the clock output, and polls for lock with a timeout. At the end it puts power saving back if it was on, reports any lock timeout, and pulses done.

Top module: `dll_pwrup_seq`

## Requirements
- R1: After a synchronous reset, busy_o, done_o, err_o and wr_vld_o are 0, dll_rst_o, dll_pdn_o and dll_clkdis_o are 1, and dll_ckout_o is 0.
- R2: A start_i pulse while idle raises busy_o one cycle later. A start_i pulse during a run has no effect: the run's write list stays the same and no second run follows.
- R3: The first write of every run goes to clock-control (address 0) with the power-save bit (bit 1) cleared. pwrsave_o is 0 when the clock output is enabled.
- R4: The writes follow this address order: clock-control 0; DLL config 1 (clock output, bit 19, cleared); DLL config 2 at address 2 (clock-disable, bit 21, set); DLL config (reset bit 30 and power-down bit 29 set); DLL config 3 at address 3; user control 5; test control 6, which is left out when skip_test_i was 1 at start; DDR config 4; DLL config 2; DLL config. Each read-modify-write changes only the named bits.
- R5: Override slot k of ovr_val_i/ovr_vld_i is used when its valid bit is 1 and its value is non-zero. Otherwise the default is used. Slots: 0 DLL config 3 (default 0x10), 1 user control, 2 test control, 3 DDR config, 4 DLL config 2, 5 DLL config. The DLL config 2 value is OR'd with clock-disable. An override for DLL config is OR'd with reset and power-down. Without one, DLL config gets 0x6007642C.
- R6: The write that follows the DLL config write of R4 is issued between WAIT_CYC and WAIT_CYC+4 cycles later, where WAIT_CYC = CLK_HZ/1e6 × WAIT_US.
- R7: After the settle wait, DLL config is written with reset and power-down both cleared, then with reset set, then with reset cleared. DLL config 2 is then written with clock-disable cleared.
- R8: At least DLL_TICKS cycles with dll_tick_i high lie between the clock-disable clear write and the write that sets the clock output bit (bit 19) in DLL config.
- R9: After the clock output is enabled, the run waits for the captured lock bit. When lock arrives, err_o is 0 at done.
- R10: If lock does not arrive within LOCK_TIMEOUT cycles, err_o is 1 at done. The power-save restore step still runs.
- R11: If the power-save bit was 1 at start, the last write of the run sets it again at clock-control. If the bit was 0, no write follows the clock-output write.
- R12: done_o is high for exactly one cycle per run, with busy_o low in that cycle. wr_vld_o is high only while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, one-cycle pulse |
| skip_test_i | input | 1 | Leave out the test-control write |
| pwrsave_req_i | input | 1 | Power-save setting followed by the clock-control register while idle |
| ovr_vld_i | input | 6 | Valid flag for each override slot |
| ovr_val_i | input | 6x32 | Override values, slot order as in R5 |
| dll_tick_i | input | 1 | Synchronised enable, one per DLL input-clock edge |
| lock_i | input | 1 | Synchronised lock indication from the DLL |
| wr_vld_o | output | 1 | A register write is being issued |
| wr_addr_o | output | 3 | Address of the write |
| wr_data_o | output | 32 | Data of the write |
| dll_rst_o | output | 1 | DLL reset control bit |
| dll_pdn_o | output | 1 | DLL power-down control bit |
| dll_clkdis_o | output | 1 | DLL input-clock gate |
| dll_ckout_o | output | 1 | DLL clock-output enable |
| pwrsave_o | output | 1 | Clock-control power-save bit |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | End of run, one-cycle pulse |
| err_o | output | 1 | Lock timed out in the last run |

## Verification
On every cycle the assertions check that the clock output is enabled only while reset, power-down, clock-gate and power-save are all off. They also check that reset and power-down are released together, that done is a lone pulse outside a run, that no write falls outside a run, and that a run begins only on a start request. Write values and order, the override-or-default choice, the length of both waits, the lock timeout and the conditional power-save restore can only be shown by the bench's scenarios. The bench sweeps power-save on and off, test-step skip on and off, and four override patterns, including valid-but-zero values, and it adds a restart attempt and runs that never lock.

// File: rtl/dllseq_pkg.sv
package dllseq_pkg;

  localparam int REG_W = 32;
  localparam int NREG  = 8;
  localparam int NOVR  = 6;

  typedef enum logic [2:0] {
    A_CLK  = 3'd0,
    A_CFG  = 3'd1,
    A_CFG2 = 3'd2,
    A_CFG3 = 3'd3,
    A_DDR  = 3'd4,
    A_USER = 3'd5,
    A_TEST = 3'd6,
    A_STAT = 3'd7
  } reg_addr_e;

  // bit positions decoded by the DLL and the clock gate
  localparam int PS_BIT     = 1;
  localparam int RST_BIT    = 30;
  localparam int PDN_BIT    = 29;
  localparam int CKOUT_BIT  = 19;
  localparam int CLKDIS_BIT = 21;
  localparam int LOCK_BIT   = 7;

  localparam logic [REG_W-1:0] PS_M     = REG_W'(1) << PS_BIT;
  localparam logic [REG_W-1:0] RST_M    = REG_W'(1) << RST_BIT;
  localparam logic [REG_W-1:0] PDN_M    = REG_W'(1) << PDN_BIT;
  localparam logic [REG_W-1:0] CKOUT_M  = REG_W'(1) << CKOUT_BIT;
  localparam logic [REG_W-1:0] CLKDIS_M = REG_W'(1) << CLKDIS_BIT;

  // override slot numbers
  localparam int O_CFG3 = 0;
  localparam int O_USER = 1;
  localparam int O_TEST = 2;
  localparam int O_DDR  = 3;
  localparam int O_CFG2 = 4;
  localparam int O_CFG  = 5;

  typedef enum logic [4:0] {
    S_IDLE, S_PS_OFF, S_CKOUT_OFF, S_CLKDIS_ON, S_RSTPDN_ON,
    S_CFG3, S_USER, S_TEST, S_DDR, S_CFG2, S_CFG,
    S_WAIT_US, S_RSTPDN_OFF, S_RST_ON, S_RST_OFF, S_CLKDIS_OFF,
    S_WAIT_TICK, S_CKOUT_ON, S_POLL, S_PS_RESTORE
  } seq_state_e;

  function automatic logic [REG_W-1:0] pick(input logic vld,
                                            input logic [REG_W-1:0] val,
                                            input logic [REG_W-1:0] def);
    return (vld && (val != '0)) ? val : def;
  endfunction

endpackage

// File: rtl/dllseq_timer.sv
module dllseq_timer #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  input  logic          en_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (load_i)
      cnt_q <= val_i;
    else if (en_i && (cnt_q != '0))
      cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/dllseq_regbank.sv
module dllseq_regbank
  import dllseq_pkg::*;
#(
  parameter logic [REG_W-1:0] DEF_CFG  = 32'h6007_642C,
  parameter logic [REG_W-1:0] DEF_CFG2 = 32'h0002_0000,
  parameter logic [REG_W-1:0] DEF_CFG3 = 32'h0000_0010,
  parameter logic [REG_W-1:0] DEF_DDR  = 32'h8004_0873,
  parameter logic [REG_W-1:0] DEF_USER = 32'h2C01_0800,
  parameter logic [REG_W-1:0] DEF_TEST = 32'h0000_0000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_vld_i,
  input  reg_addr_e        wr_addr_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             hold_i,
  input  logic             pwrsave_req_i,
  input  logic             lock_i,
  output logic [REG_W-1:0] clk_o,
  output logic [REG_W-1:0] cfg_o,
  output logic [REG_W-1:0] cfg2_o,
  output logic             lock_o
);
  function automatic logic [REG_W-1:0] rst_val(input int i);
    case (i)
      1:       return DEF_CFG;
      2:       return DEF_CFG2 | CLKDIS_M;
      3:       return DEF_CFG3;
      4:       return DEF_DDR;
      5:       return DEF_USER;
      6:       return DEF_TEST;
      default: return '0;
    endcase
  endfunction

  logic [REG_W-1:0] rv [NREG];
  logic             stat_q;

  for (genvar i = 0; i < NREG - 1; i++) begin : g_reg
    localparam logic [REG_W-1:0] RV = rst_val(i);
    logic [REG_W-1:0] q;
    if (i == 0) begin : g_clk
      always_ff @(posedge clk) begin
        if (rst)
          q <= RV;
        else if (wr_vld_i && (wr_addr_i == reg_addr_e'(i)))
          q <= wr_data_i;
        else if (!hold_i)
          q[PS_BIT] <= pwrsave_req_i;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (rst)
          q <= RV;
        else if (wr_vld_i && (wr_addr_i == reg_addr_e'(i)))
          q <= wr_data_i;
      end
    end
    assign rv[i] = q;
  end

  always_ff @(posedge clk) begin
    if (rst) stat_q <= 1'b0;
    else     stat_q <= lock_i;
  end

  assign rv[NREG-1] = REG_W'(stat_q) << LOCK_BIT;

  assign clk_o  = rv[int'(A_CLK)];
  assign cfg_o  = rv[int'(A_CFG)];
  assign cfg2_o = rv[int'(A_CFG2)];
  assign lock_o = rv[int'(A_STAT)][LOCK_BIT];
endmodule

// File: rtl/dllseq_fsm.sv
module dllseq_fsm
  import dllseq_pkg::*;
#(
  parameter int CW           = 10,
  parameter int WAIT_CYC     = 6500,
  parameter int DLL_TICKS    = 8000,
  parameter int LOCK_TIMEOUT = 4096,
  parameter logic [REG_W-1:0] DEF_CFG  = 32'h6007_642C,
  parameter logic [REG_W-1:0] DEF_CFG2 = 32'h0002_0000,
  parameter logic [REG_W-1:0] DEF_CFG3 = 32'h0000_0010,
  parameter logic [REG_W-1:0] DEF_DDR  = 32'h8004_0873,
  parameter logic [REG_W-1:0] DEF_USER = 32'h2C01_0800,
  parameter logic [REG_W-1:0] DEF_TEST = 32'h0000_0000
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start_i,
  input  logic                       skip_test_i,
  input  logic [NOVR-1:0]            ovr_vld_i,
  input  logic [NOVR-1:0][REG_W-1:0] ovr_val_i,
  input  logic                       dll_tick_i,
  input  logic [REG_W-1:0]           clk_reg_i,
  input  logic [REG_W-1:0]           cfg_i,
  input  logic [REG_W-1:0]           cfg2_i,
  input  logic                       lock_i,
  input  logic                       tmr_zero_i,
  output logic                       tmr_load_o,
  output logic [CW-1:0]              tmr_val_o,
  output logic                       tmr_en_o,
  output logic                       wr_vld_o,
  output reg_addr_e                  wr_addr_o,
  output logic [REG_W-1:0]           wr_data_o,
  output logic                       busy_o,
  output logic                       done_o,
  output logic                       err_o
);
  seq_state_e       state_q;
  logic             gap_q;
  logic             ps_saved_q;
  logic             skip_q;
  reg_addr_e        n_addr;
  logic [REG_W-1:0] n_data;
  logic             skip_step;

  function automatic seq_state_e succ(input seq_state_e s);
    case (s)
      S_PS_OFF:     return S_CKOUT_OFF;
      S_CKOUT_OFF:  return S_CLKDIS_ON;
      S_CLKDIS_ON:  return S_RSTPDN_ON;
      S_RSTPDN_ON:  return S_CFG3;
      S_CFG3:       return S_USER;
      S_USER:       return S_TEST;
      S_TEST:       return S_DDR;
      S_DDR:        return S_CFG2;
      S_CFG2:       return S_CFG;
      S_CFG:        return S_WAIT_US;
      S_WAIT_US:    return S_RSTPDN_OFF;
      S_RSTPDN_OFF: return S_RST_ON;
      S_RST_ON:     return S_RST_OFF;
      S_RST_OFF:    return S_CLKDIS_OFF;
      S_CLKDIS_OFF: return S_WAIT_TICK;
      S_WAIT_TICK:  return S_CKOUT_ON;
      S_CKOUT_ON:   return S_POLL;
      S_POLL:       return S_PS_RESTORE;
      default:      return S_IDLE;
    endcase
  endfunction

  // address and data of the write for the current step
  always_comb begin
    n_addr = A_CLK;
    n_data = '0;
    case (state_q)
      S_PS_OFF:     begin n_addr = A_CLK;  n_data = clk_reg_i & ~PS_M; end
      S_CKOUT_OFF:  begin n_addr = A_CFG;  n_data = cfg_i & ~CKOUT_M; end
      S_CLKDIS_ON:  begin n_addr = A_CFG2; n_data = cfg2_i | CLKDIS_M; end
      S_RSTPDN_ON:  begin n_addr = A_CFG;  n_data = cfg_i | RST_M | PDN_M; end
      S_CFG3:       begin n_addr = A_CFG3;
                          n_data = pick(ovr_vld_i[O_CFG3], ovr_val_i[O_CFG3], DEF_CFG3); end
      S_USER:       begin n_addr = A_USER;
                          n_data = pick(ovr_vld_i[O_USER], ovr_val_i[O_USER], DEF_USER); end
      S_TEST:       begin n_addr = A_TEST;
                          n_data = pick(ovr_vld_i[O_TEST], ovr_val_i[O_TEST], DEF_TEST); end
      S_DDR:        begin n_addr = A_DDR;
                          n_data = pick(ovr_vld_i[O_DDR], ovr_val_i[O_DDR], DEF_DDR); end
      S_CFG2:       begin n_addr = A_CFG2;
                          n_data = pick(ovr_vld_i[O_CFG2], ovr_val_i[O_CFG2], DEF_CFG2) | CLKDIS_M; end
      S_CFG:        begin n_addr = A_CFG;
                          n_data = (ovr_vld_i[O_CFG] && (ovr_val_i[O_CFG] != '0))
                                   ? (ovr_val_i[O_CFG] | RST_M | PDN_M) : DEF_CFG; end
      S_RSTPDN_OFF: begin n_addr = A_CFG;  n_data = cfg_i & ~(RST_M | PDN_M); end
      S_RST_ON:     begin n_addr = A_CFG;  n_data = cfg_i | RST_M; end
      S_RST_OFF:    begin n_addr = A_CFG;  n_data = cfg_i & ~RST_M; end
      S_CLKDIS_OFF: begin n_addr = A_CFG2; n_data = cfg2_i & ~CLKDIS_M; end
      S_CKOUT_ON:   begin n_addr = A_CFG;  n_data = cfg_i | CKOUT_M; end
      S_PS_RESTORE: begin n_addr = A_CLK;  n_data = clk_reg_i | PS_M; end
      default:      begin n_addr = A_CLK;  n_data = '0; end
    endcase
  end

  assign skip_step = ((state_q == S_TEST) && skip_q) ||
                     ((state_q == S_PS_RESTORE) && !ps_saved_q);

  // timer control: loaded in the settle cycle of the step before a wait
  always_comb begin
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    if (gap_q) begin
      case (state_q)
        S_CFG:        begin tmr_load_o = 1'b1; tmr_val_o = CW'(WAIT_CYC - 1); end
        S_CLKDIS_OFF: begin tmr_load_o = 1'b1; tmr_val_o = CW'(DLL_TICKS); end
        S_CKOUT_ON:   begin tmr_load_o = 1'b1; tmr_val_o = CW'(LOCK_TIMEOUT); end
        default:      ;
      endcase
    end
  end

  assign tmr_en_o = (state_q == S_WAIT_US) || (state_q == S_POLL) ||
                    ((state_q == S_WAIT_TICK) && dll_tick_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= S_IDLE;
      gap_q      <= 1'b0;
      ps_saved_q <= 1'b0;
      skip_q     <= 1'b0;
      wr_vld_o   <= 1'b0;
      wr_addr_o  <= A_CLK;
      wr_data_o  <= '0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      wr_vld_o <= 1'b0;
      done_o   <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (start_i) begin
            state_q    <= S_PS_OFF;
            ps_saved_q <= clk_reg_i[PS_BIT];
            skip_q     <= skip_test_i;
            err_o      <= 1'b0;
            gap_q      <= 1'b0;
          end
        end
        S_WAIT_US, S_WAIT_TICK: begin
          if (tmr_zero_i) state_q <= succ(state_q);
        end
        S_POLL: begin
          if (lock_i) begin
            state_q <= S_PS_RESTORE;
          end else if (tmr_zero_i) begin
            err_o   <= 1'b1;
            state_q <= S_PS_RESTORE;
          end
        end
        default: begin
          if (skip_step) begin
            state_q <= succ(state_q);
            if (succ(state_q) == S_IDLE) done_o <= 1'b1;
          end else if (!gap_q) begin
            wr_vld_o  <= 1'b1;
            wr_addr_o <= n_addr;
            wr_data_o <= n_data;
            gap_q     <= 1'b1;
          end else begin
            gap_q   <= 1'b0;
            state_q <= succ(state_q);
            if (succ(state_q) == S_IDLE) done_o <= 1'b1;
          end
        end
      endcase
    end
  end

  assign busy_o = (state_q != S_IDLE);
endmodule

// File: rtl/dll_pwrup_seq.sv
module dll_pwrup_seq
  import dllseq_pkg::*;
#(
  parameter int CLK_HZ       = 125_000_000,
  parameter int WAIT_US      = 52,
  parameter int DLL_TICKS    = 8000,
  parameter int LOCK_TIMEOUT = 4096,
  parameter logic [REG_W-1:0] DEF_CFG  = 32'h6007_642C,
  parameter logic [REG_W-1:0] DEF_CFG2 = 32'h0002_0000,
  parameter logic [REG_W-1:0] DEF_CFG3 = 32'h0000_0010,
  parameter logic [REG_W-1:0] DEF_DDR  = 32'h8004_0873,
  parameter logic [REG_W-1:0] DEF_USER = 32'h2C01_0800,
  parameter logic [REG_W-1:0] DEF_TEST = 32'h0000_0000
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start_i,
  input  logic                       skip_test_i,
  input  logic                       pwrsave_req_i,
  input  logic [NOVR-1:0]            ovr_vld_i,
  input  logic [NOVR-1:0][REG_W-1:0] ovr_val_i,
  input  logic                       dll_tick_i,
  input  logic                       lock_i,
  output logic                       wr_vld_o,
  output logic [2:0]                 wr_addr_o,
  output logic [REG_W-1:0]           wr_data_o,
  output logic                       dll_rst_o,
  output logic                       dll_pdn_o,
  output logic                       dll_clkdis_o,
  output logic                       dll_ckout_o,
  output logic                       pwrsave_o,
  output logic                       busy_o,
  output logic                       done_o,
  output logic                       err_o
);
  localparam int WAIT_CYC = (CLK_HZ / 1_000_000) * WAIT_US;
  localparam int MAX_AB   = (WAIT_CYC > DLL_TICKS) ? WAIT_CYC : DLL_TICKS;
  localparam int MAXC     = (MAX_AB > LOCK_TIMEOUT) ? MAX_AB : LOCK_TIMEOUT;
  localparam int CW       = $clog2(MAXC + 1);

  reg_addr_e        wr_addr_e;
  logic [REG_W-1:0] clk_reg, cfg_reg, cfg2_reg;
  logic             lock_cap;
  logic             tmr_load, tmr_en, tmr_zero;
  logic [CW-1:0]    tmr_val;

  dllseq_fsm #(
    .CW(CW), .WAIT_CYC(WAIT_CYC), .DLL_TICKS(DLL_TICKS), .LOCK_TIMEOUT(LOCK_TIMEOUT),
    .DEF_CFG(DEF_CFG), .DEF_CFG2(DEF_CFG2), .DEF_CFG3(DEF_CFG3),
    .DEF_DDR(DEF_DDR), .DEF_USER(DEF_USER), .DEF_TEST(DEF_TEST)
  ) u_fsm (
    .clk(clk), .rst(rst), .start_i(start_i), .skip_test_i(skip_test_i),
    .ovr_vld_i(ovr_vld_i), .ovr_val_i(ovr_val_i), .dll_tick_i(dll_tick_i),
    .clk_reg_i(clk_reg), .cfg_i(cfg_reg), .cfg2_i(cfg2_reg), .lock_i(lock_cap),
    .tmr_zero_i(tmr_zero), .tmr_load_o(tmr_load), .tmr_val_o(tmr_val),
    .tmr_en_o(tmr_en), .wr_vld_o(wr_vld_o), .wr_addr_o(wr_addr_e),
    .wr_data_o(wr_data_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  dllseq_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst(rst), .load_i(tmr_load), .val_i(tmr_val),
    .en_i(tmr_en), .zero_o(tmr_zero)
  );

  dllseq_regbank #(
    .DEF_CFG(DEF_CFG), .DEF_CFG2(DEF_CFG2), .DEF_CFG3(DEF_CFG3),
    .DEF_DDR(DEF_DDR), .DEF_USER(DEF_USER), .DEF_TEST(DEF_TEST)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_vld_i(wr_vld_o), .wr_addr_i(wr_addr_e),
    .wr_data_i(wr_data_o), .hold_i(busy_o), .pwrsave_req_i(pwrsave_req_i),
    .lock_i(lock_i), .clk_o(clk_reg), .cfg_o(cfg_reg), .cfg2_o(cfg2_reg),
    .lock_o(lock_cap)
  );

  assign wr_addr_o    = wr_addr_e;
  assign dll_rst_o    = cfg_reg[RST_BIT];
  assign dll_pdn_o    = cfg_reg[PDN_BIT];
  assign dll_ckout_o  = cfg_reg[CKOUT_BIT];
  assign dll_clkdis_o = cfg2_reg[CLKDIS_BIT];
  assign pwrsave_o    = clk_reg[PS_BIT];
endmodule

// File: rtl/dll_pwrup_seq_chk.sv
module dll_pwrup_seq_chk (
  input logic clk,
  input logic rst,
  input logic start_i,
  input logic wr_vld_o,
  input logic dll_rst_o,
  input logic dll_pdn_o,
  input logic dll_clkdis_o,
  input logic dll_ckout_o,
  input logic pwrsave_o,
  input logic busy_o,
  input logic done_o
);
  // R3
  ckout_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dll_ckout_o) |-> (!dll_rst_o && !dll_pdn_o && !dll_clkdis_o && !pwrsave_o));

  // R7
  release_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $fell(dll_pdn_o)) |-> !dll_rst_o);

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R12
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && $past(busy_o)));

  // R12
  wr_in_run_chk: assert property (@(posedge clk) disable iff (rst)
    wr_vld_o |-> busy_o);

  // R2
  start_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(start_i));
endmodule

bind dll_pwrup_seq dll_pwrup_seq_chk u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .wr_vld_o(wr_vld_o),
  .dll_rst_o(dll_rst_o), .dll_pdn_o(dll_pdn_o), .dll_clkdis_o(dll_clkdis_o),
  .dll_ckout_o(dll_ckout_o), .pwrsave_o(pwrsave_o), .busy_o(busy_o),
  .done_o(done_o)
);

// File: tb/dll_pwrup_seq_tb.sv
module dll_pwrup_seq_tb;
  import dllseq_pkg::*;

  localparam int CLK_HZ   = 10_000_000;
  localparam int WAIT_US  = 52;
  localparam int WAIT_CYC = 520;
  localparam int TICKS    = 200;
  localparam int TMO      = 100;
  localparam int LOCK_DLY = 20;
  localparam logic [31:0] D_CFG  = 32'h6007_642C;
  localparam logic [31:0] D_CFG2 = 32'h0002_0000;
  localparam logic [31:0] D_CFG3 = 32'h0000_0010;
  localparam logic [31:0] D_DDR  = 32'h8004_0873;
  localparam logic [31:0] D_USER = 32'h2C01_0800;
  localparam logic [31:0] D_TEST = 32'h0000_0000;
  localparam logic [31:0] M_PS = 32'h2, M_RST = 32'h4000_0000, M_PDN = 32'h2000_0000;
  localparam logic [31:0] M_CK = 32'h0008_0000, M_CD = 32'h0020_0000;

  logic clk = 0, rst = 1, start_i = 0, skip_test_i = 0, pwrsave_req_i = 0;
  logic [5:0] ovr_vld_i = '0;
  logic [5:0][31:0] ovr_val_i = '0;
  logic dll_tick_i = 0, lock_i = 0, lock_block = 0;
  logic wr_vld_o, dll_rst_o, dll_pdn_o, dll_clkdis_o, dll_ckout_o, pwrsave_o;
  logic busy_o, done_o, err_o;
  logic [2:0] wr_addr_o;
  logic [31:0] wr_data_o;

  dll_pwrup_seq #(
    .CLK_HZ(CLK_HZ), .WAIT_US(WAIT_US), .DLL_TICKS(TICKS), .LOCK_TIMEOUT(TMO),
    .DEF_CFG(D_CFG), .DEF_CFG2(D_CFG2), .DEF_CFG3(D_CFG3),
    .DEF_DDR(D_DDR), .DEF_USER(D_USER), .DEF_TEST(D_TEST)
  ) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .skip_test_i(skip_test_i),
    .pwrsave_req_i(pwrsave_req_i), .ovr_vld_i(ovr_vld_i), .ovr_val_i(ovr_val_i),
    .dll_tick_i(dll_tick_i), .lock_i(lock_i), .wr_vld_o(wr_vld_o),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .dll_rst_o(dll_rst_o),
    .dll_pdn_o(dll_pdn_o), .dll_clkdis_o(dll_clkdis_o), .dll_ckout_o(dll_ckout_o),
    .pwrsave_o(pwrsave_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // recorder, DLL tick source and lock model, all on the falling edge
  logic [2:0]  rec_a [1024];
  logic [31:0] rec_d [1024];
  int          rec_c [1024];
  int          rec_t [1024];
  logic        rec_p [1024];
  int nrec = 0, ndone = 0, tick_total = 0, lcnt = 0;

  always @(negedge clk) begin
    dll_tick_i <= ~dll_tick_i;
    if (dll_tick_i) tick_total <= tick_total + 1;
    if (!dll_ckout_o) lcnt <= 0;
    else if (lcnt < 255) lcnt <= lcnt + 1;
    lock_i <= !lock_block && dll_ckout_o && (lcnt >= LOCK_DLY);
    if (done_o) ndone <= ndone + 1;
    if (wr_vld_o && nrec < 1024) begin
      rec_a[nrec] <= wr_addr_o;
      rec_d[nrec] <= wr_data_o;
      rec_c[nrec] <= cyc;
      rec_t[nrec] <= tick_total;
      rec_p[nrec] <= pwrsave_o;
      nrec <= nrec + 1;
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // bench model of the two read-modify-write registers
  logic [31:0] m_cfg = D_CFG, m_cfg2 = D_CFG2 | M_CD;
  logic [2:0]  ea [32];
  logic [31:0] ed [32];
  string       er [32];
  int ne;

  task automatic push(input logic [2:0] a, input logic [31:0] d, input string rq);
    ea[ne] = a; ed[ne] = d; er[ne] = rq; ne++;
  endtask

  function automatic logic [31:0] sel(input int k, input logic [31:0] def);
    return (ovr_vld_i[k] && ovr_val_i[k] != 0) ? ovr_val_i[k] : def;
  endfunction

  task automatic run_case(input bit ps, input bit skip, input int pat, input bit blk, input bit restart);
    int base, dbase, n, i10, i15, i17, dcyc, got;
    bit errv;
    pwrsave_req_i = ps; skip_test_i = skip; lock_block = blk;
    for (int k = 0; k < 6; k++) begin
      case (pat)
        0: begin ovr_vld_i[k] = 0; ovr_val_i[k] = 32'h1357_0000 + k; end
        1: begin ovr_vld_i[k] = 1; ovr_val_i[k] = (k + 1) * 32'h0101_0101 ^ 32'h0040_0000; end
        2: begin ovr_vld_i[k] = 1; ovr_val_i[k] = 0; end
        default: begin ovr_vld_i[k] = (k % 2 == 0); ovr_val_i[k] = 32'h0A0B_0000 | (k << 4) | 1; end
      endcase
    end
    repeat (4) @(negedge clk);
    base = nrec; dbase = ndone;
    start_i = 1; @(negedge clk); start_i = 0;
    chk(busy_o == 1, "R2 busy after start", busy_o, 1);
    if (restart) begin
      repeat (30) @(negedge clk);
      start_i = 1; @(negedge clk); start_i = 0;
    end
    n = 0;
    while (!done_o && n < 20000) begin @(negedge clk); n++; end
    chk(done_o == 1, "R12 done seen", done_o, 1);
    chk(busy_o == 0, "R12 busy low with done", busy_o, 0);
    errv = err_o; dcyc = cyc;
    chk(errv == blk, blk ? "R10 timeout error" : "R9 lock no error", errv, blk);
    @(negedge clk);
    chk(done_o == 0, "R12 done one cycle", done_o, 0);
    @(negedge clk);
    chk(pwrsave_o == ps, "R11 power-save after run", pwrsave_o, ps);
    chk(ndone - dbase == 1, "R2 single run", ndone - dbase, 1);

    // expected write list
    ne = 0;
    push(3'd0, (ps ? M_PS : 32'h0) & ~M_PS, "R3");
    m_cfg = m_cfg & ~M_CK;       push(3'd1, m_cfg, "R4");
    m_cfg2 = m_cfg2 | M_CD;      push(3'd2, m_cfg2, "R4");
    m_cfg = m_cfg | M_RST | M_PDN; push(3'd1, m_cfg, "R4");
    push(3'd3, sel(0, D_CFG3), "R5");
    push(3'd5, sel(1, D_USER), "R5");
    if (!skip) push(3'd6, sel(2, D_TEST), "R4");
    push(3'd4, sel(3, D_DDR), "R5");
    m_cfg2 = sel(4, D_CFG2) | M_CD; push(3'd2, m_cfg2, "R5");
    m_cfg = (ovr_vld_i[5] && ovr_val_i[5] != 0) ? (ovr_val_i[5] | M_RST | M_PDN) : D_CFG;
    i10 = ne; push(3'd1, m_cfg, "R5");
    m_cfg = m_cfg & ~(M_RST | M_PDN); push(3'd1, m_cfg, "R7");
    m_cfg = m_cfg | M_RST;           push(3'd1, m_cfg, "R7");
    m_cfg = m_cfg & ~M_RST;          push(3'd1, m_cfg, "R7");
    m_cfg2 = m_cfg2 & ~M_CD; i15 = ne; push(3'd2, m_cfg2, "R7");
    m_cfg = m_cfg | M_CK;    i17 = ne; push(3'd1, m_cfg, "R8");
    if (ps) push(3'd0, M_PS, "R11");

    got = nrec - base;
    chk(got == ne, restart ? "R2 restart ignored, write count" : "R11 write count", got, ne);
    for (int k = 0; k < ne && k < got; k++) begin
      chk(rec_a[base+k] == ea[k], er[k], rec_a[base+k], ea[k]);
      chk(rec_d[base+k] == ed[k], er[k], rec_d[base+k], ed[k]);
    end
    if (got >= ne) begin
      n = rec_c[base+i10+1] - rec_c[base+i10];
      chk(n >= WAIT_CYC && n <= WAIT_CYC + 4, "R6 settle wait", n, WAIT_CYC);
      n = rec_t[base+i17] - rec_t[base+i15];
      chk(n >= TICKS, "R8 tick wait", n, TICKS);
      chk(rec_p[base+i17] == 0, "R3 power-save off at clock enable", rec_p[base+i17], 0);
      if (blk) chk(dcyc - rec_c[base+i17] >= TMO, "R10 timeout length", dcyc - rec_c[base+i17], TMO);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(busy_o == 0 && done_o == 0 && err_o == 0 && wr_vld_o == 0, "R1 idle flags",
        {busy_o, done_o, err_o, wr_vld_o}, 0);
    chk(dll_rst_o && dll_pdn_o && dll_clkdis_o && !dll_ckout_o, "R1 DLL control bits",
        {dll_rst_o, dll_pdn_o, dll_clkdis_o, dll_ckout_o}, 4'b1110);
    for (int ps = 0; ps < 2; ps++)
      for (int sk = 0; sk < 2; sk++)
        for (int p = 0; p < 4; p++)
          run_case(ps[0], sk[0], p, 1'b0, (p == 0 && sk == 0));
    run_case(1'b1, 1'b0, 1, 1'b1, 1'b0);
    run_case(1'b0, 1'b1, 3, 1'b1, 1'b0);
    run_case(1'b1, 1'b1, 0, 1'b0, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule